// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Overrun Detection

This block takes a single asynchronous serial input, oversamples it sixteen times per bit, and recovers frames made of a low start bit, eight data bits sent least significant first, and a high stop bit. The start and stop bits are stripped. The eight data bits go into a receive data register that the host reads. A full flag marks the register as holding unread data. Error flags report noise inside a bit and a missing stop bit. An overrun flag reports that data was lost.

Two frames can be stored at once. If the data register still holds unread data when a new frame completes, that frame stays parked in the shift stage. It moves across as soon as the host empties the register. When a third frame starts while both places are occupied, the overrun flag is set and that third frame is thrown away. The host clears the flags in two steps. First it reads status while the full flag is set, which arms the clear. Then it reads the data register. An interrupt request follows the full flag whenever the interrupt arm bit is set.

Top module: `serial_rx_overrun`

## Requirements
- R1: After reset, every flag output, the interrupt request and the data register are 0.
- R2: A frame with a start bit (0), eight data bits sent least significant first, and a stop bit (1) loads those eight bits into `rx_data` and sets `st_full`.
- R3: A low pulse on `rxd` is taken as a start bit only if the majority of samples 7, 8 and 9 of that bit are 0. A shorter low pulse is ignored and leaves `st_full` at 0.
- R4: One bit lasts 16 ticks. One tick lasts `baud_div` clock cycles. A value of 0 is treated as 1.
- R5: `st_full`, `st_noise`, `st_frame` and `st_overrun` clear only when a data read follows a status read that saw `st_full` at 1. A data read on its own changes nothing.
- R6: A frame that completes while `st_full` is 1 is held back. After the clear sequence it moves into `rx_data` and `st_full` goes back to 1.
- R7: A start bit that is confirmed while one frame is held back and `st_full` is 1 sets `st_overrun`. That frame is then discarded.
- R8: `st_noise` is set when samples 7, 8 and 9 of any bit in a frame disagree. The data bit still takes the majority value.
- R9: `st_frame` is set when the majority of the stop bit samples is 0. The data is still loaded.
- R10: `rx_irq` is 1 exactly when `rx_irq_en` is 1 and `st_full` is 1.
- R11: While `rx_en` is 0, no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| rx_irq_en | input | 1 | Receive interrupt arm bit |
| baud_div | input | BDW | Clock cycles per 1/16 bit |
| rxd | input | 1 | Serial input line, high when idle |
| stat_rd | input | 1 | Single-cycle pulse for a status read |
| data_rd | input | 1 | Single-cycle pulse for a data register read |
| rx_data | output | 8 | Receive data register |
| st_full | output | 1 | Data register full flag |
| st_overrun | output | 1 | Overrun flag |
| st_noise | output | 1 | Noise flag |
| st_frame | output | 1 | Framing error flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The input passes through a two-stage synchronizer, so a start edge is seen up to `baud_div`+2 cycles late. Each bit is decided at its ninth sample. A finished frame therefore reaches `rx_data` and `st_full` about nine sixteenths of the way into the stop bit, plus one register stage. The bench checks the data register and flags only after it has driven the whole stop bit and an idle bit time. The glitch in the noise test lasts exactly one tick and is placed between samples 7 and 9. Flag clears and the move of a held-back frame come one and two cycles after the data read pulse. The bench samples them on a falling edge a few cycles after that pulse.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int DATA_W   = 8;
  localparam int OVS      = 16;
  localparam int SAMP_W   = $clog2(OVS + 1);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int BIT_W    = $clog2(FRAME_BITS);
  localparam int SAMP_LO  = 7;
  localparam int SAMP_MID = 8;
  localparam int SAMP_HI  = 9;

  typedef enum logic [0:0] { RX_IDLE, RX_BUSY } rx_state_t;

  // majority of three samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // samples do not all agree
  function automatic logic split3(input logic a, input logic b, input logic c);
    return !((a == b) && (b == c));
  endfunction

  // last clock of a tick period; divisor 0 treated as 1
  function automatic logic tick_end(input int unsigned cnt, input int unsigned div);
    int unsigned lim;
    lim = (div == 0) ? 0 : div - 1;
    return cnt >= lim;
  endfunction
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int BDW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BDW-1:0] baud_div,
  output logic           tick
);
  import srx_pkg::*;
  logic [BDW-1:0] cnt;
  logic           at_end;

  always_comb at_end = tick_end(int'(unsigned'(cnt)), int'(unsigned'(baud_div)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= at_end;
      cnt  <= at_end ? '0 : cnt + 1'b1;
    end
  end

  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && baud_div > 1) |=> !tick);
endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_en,
  input  logic                      tick,
  input  logic                      rxs,
  output logic                      start_ok,
  output logic                      frame_done,
  output logic [srx_pkg::DATA_W-1:0] f_data,
  output logic                      f_noise,
  output logic                      f_ferr
);
  import srx_pkg::*;
  rx_state_t           state;
  logic [SAMP_W-1:0]   samp;
  logic [BIT_W-1:0]    bitn;
  logic                prev_hi;
  logic                s_lo, s_mid;
  logic [DATA_W-1:0]   shreg;
  logic                nz_acc;
  logic                decide, bit_val, bit_nz;

  always_comb begin
    decide  = (state == RX_BUSY) && tick && (samp == SAMP_W'(SAMP_HI));
    bit_val = vote3(s_lo, s_mid, rxs);
    bit_nz  = split3(s_lo, s_mid, rxs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      samp       <= '0;
      bitn       <= '0;
      prev_hi    <= 1'b0;
      s_lo       <= 1'b1;
      s_mid      <= 1'b1;
      shreg      <= '0;
      nz_acc     <= 1'b0;
      start_ok   <= 1'b0;
      frame_done <= 1'b0;
      f_data     <= '0;
      f_noise    <= 1'b0;
      f_ferr     <= 1'b0;
    end else begin
      start_ok   <= 1'b0;
      frame_done <= 1'b0;
      if (!rx_en) begin
        state   <= RX_IDLE;
        prev_hi <= 1'b0;
      end else if (tick) begin
        if (state == RX_IDLE) begin
          prev_hi <= rxs;
          if (prev_hi && !rxs) begin
            state  <= RX_BUSY;
            samp   <= SAMP_W'(1);
            bitn   <= '0;
            nz_acc <= 1'b0;
          end
        end else begin
          if (samp == SAMP_W'(SAMP_LO))  s_lo  <= rxs;
          if (samp == SAMP_W'(SAMP_MID)) s_mid <= rxs;
          samp <= (samp == SAMP_W'(OVS)) ? SAMP_W'(1) : samp + 1'b1;
          if (samp == SAMP_W'(OVS)) bitn <= bitn + 1'b1;
          if (decide) begin
            if (bitn == '0) begin
              if (bit_val) begin
                state   <= RX_IDLE;
                prev_hi <= rxs;
              end else begin
                start_ok <= 1'b1;
                nz_acc   <= bit_nz;
              end
            end else if (bitn == BIT_W'(FRAME_BITS - 1)) begin
              frame_done <= 1'b1;
              f_data     <= shreg;
              f_noise    <= nz_acc | bit_nz;
              f_ferr     <= !bit_val;
              state      <= RX_IDLE;
              prev_hi    <= rxs;
            end else begin
              shreg  <= {bit_val, shreg[DATA_W-1:1]};
              nz_acc <= nz_acc | bit_nz;
            end
          end
        end
      end
    end
  end

  p_start_before_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && frame_done));
  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state == RX_IDLE) && !frame_done);
endmodule

// File: rtl/srx_hold_regs.sv
module srx_hold_regs (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rx_en,
  input  logic                       frame_done,
  input  logic [srx_pkg::DATA_W-1:0] f_data,
  input  logic                       f_noise,
  input  logic                       f_ferr,
  input  logic                       start_ok,
  input  logic                       stat_rd,
  input  logic                       data_rd,
  output logic [srx_pkg::DATA_W-1:0] hold_data,
  output logic                       full,
  output logic                       noise,
  output logic                       ferr,
  output logic                       ovr
);
  import srx_pkg::*;
  logic              armed, parked, drop;
  logic [DATA_W-1:0] park_data;
  logic              park_nz, park_fe;
  logic              clear_seq, move, load_direct, park_new, ovr_set;

  always_comb begin
    clear_seq   = data_rd && armed;
    move        = !full && parked;
    load_direct = frame_done && !drop && !full && !parked;
    park_new    = frame_done && !drop && !load_direct;
    ovr_set     = start_ok && parked && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data <= '0;
      full      <= 1'b0;
      noise     <= 1'b0;
      ferr      <= 1'b0;
      ovr       <= 1'b0;
      armed     <= 1'b0;
      parked    <= 1'b0;
      drop      <= 1'b0;
      park_data <= '0;
      park_nz   <= 1'b0;
      park_fe   <= 1'b0;
    end else begin
      if (clear_seq) begin
        full  <= 1'b0;
        noise <= 1'b0;
        ferr  <= 1'b0;
        ovr   <= 1'b0;
        armed <= 1'b0;
      end else if (stat_rd && full) begin
        armed <= 1'b1;
      end
      if (move) begin
        full      <= 1'b1;
        hold_data <= park_data;
        noise     <= noise | park_nz;
        ferr      <= ferr | park_fe;
      end else if (load_direct) begin
        full      <= 1'b1;
        hold_data <= f_data;
        noise     <= noise | f_noise;
        ferr      <= ferr | f_ferr;
      end
      if (park_new) begin
        parked    <= 1'b1;
        park_data <= f_data;
        park_nz   <= f_noise;
        park_fe   <= f_ferr;
      end else if (move) begin
        parked <= 1'b0;
      end
      if (ovr_set) ovr <= 1'b1;
      if (!rx_en) drop <= 1'b0;
      else if (ovr_set) drop <= 1'b1;
      else if (frame_done && drop) drop <= 1'b0;
    end
  end

  p_clear_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(data_rd) && $past(armed));
  p_parked_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !full) |=> full && !$past(park_new) |-> !parked);
  p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(parked) && $past(start_ok));
endmodule

// File: rtl/serial_rx_overrun.sv
module serial_rx_overrun #(
  parameter int BDW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_en,
  input  logic           rx_irq_en,
  input  logic [BDW-1:0] baud_div,
  input  logic           rxd,
  input  logic           stat_rd,
  input  logic           data_rd,
  output logic [7:0]     rx_data,
  output logic           st_full,
  output logic           st_overrun,
  output logic           st_noise,
  output logic           st_frame,
  output logic           rx_irq
);
  import srx_pkg::*;
  logic [1:0]        sync;
  logic              tick, start_ok, frame_done, f_noise, f_ferr;
  logic [DATA_W-1:0] f_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  srx_tick_gen #(.BDW(BDW)) u_tick (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tick(tick)
  );

  srx_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tick(tick), .rxs(sync[1]),
    .start_ok(start_ok), .frame_done(frame_done), .f_data(f_data),
    .f_noise(f_noise), .f_ferr(f_ferr)
  );

  srx_hold_regs u_hold (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .frame_done(frame_done),
    .f_data(f_data), .f_noise(f_noise), .f_ferr(f_ferr), .start_ok(start_ok),
    .stat_rd(stat_rd), .data_rd(data_rd), .hold_data(rx_data), .full(st_full),
    .noise(st_noise), .ferr(st_frame), .ovr(st_overrun)
  );

  always_comb rx_irq = rx_irq_en && st_full;

  p_irq_follows_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> st_full);
  p_flags_need_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_noise || st_frame) |-> st_full);
endmodule

// File: tb/tb_serial_rx_overrun.sv
module tb_serial_rx_overrun;
  logic clk = 0, rst_n = 0, rx_en = 0, rx_irq_en = 0, rxd = 1;
  logic stat_rd = 0, data_rd = 0;
  logic [11:0] baud_div = 12'd4;
  logic [7:0] rx_data;
  logic st_full, st_overrun, st_noise, st_frame, rx_irq;
  int vectors = 0, errs = 0;
  int br = 4;

  always #2.5 clk = ~clk;

  serial_rx_overrun dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_irq_en(rx_irq_en),
    .baud_div(baud_div), .rxd(rxd), .stat_rd(stat_rd), .data_rd(data_rd),
    .rx_data(rx_data), .st_full(st_full), .st_overrun(st_overrun),
    .st_noise(st_noise), .st_frame(st_frame), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic stop_v, input int glitch_bit);
    int p;
    p = 16 * br;
    for (int b = 0; b < 10; b++) begin
      logic v;
      v = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
      rxd = v;
      if (b == glitch_bit) begin
        clocks(7 * br + br / 2 + 2);
        rxd = !v;
        clocks(br);
        rxd = v;
        clocks(p - (8 * br + br / 2 + 2));
      end else begin
        clocks(p);
      end
    end
    rxd = 1;
    clocks(p);
  endtask

  task automatic rd_status();
    stat_rd = 1; clocks(1); stat_rd = 0; clocks(2);
  endtask

  task automatic rd_data();
    data_rd = 1; clocks(1); data_rd = 0; clocks(3);
  endtask

  task automatic t_reset();
    settle();
    chk("R1 full", st_full, 0);
    chk("R1 flags", {st_overrun, st_noise, st_frame, rx_irq}, 0);
    chk("R1 data", rx_data, 0);
  endtask

  task automatic t_basic();
    send_frame(8'hA5, 1, -1);
    settle();
    chk("R2 data", rx_data, 8'hA5);
    chk("R2 full", st_full, 1);
    chk("R10 irq unarmed", rx_irq, 0);
    clocks(1);
    rx_irq_en = 1; settle();
    chk("R10 irq armed", rx_irq, 1);
    clocks(1);
    rd_data(); settle();
    chk("R5 lone data read", st_full, 1);
    clocks(1);
    rd_status(); rd_data(); settle();
    chk("R5 cleared", st_full, 0);
    chk("R10 irq drops", rx_irq, 0);
    clocks(1);
    rx_irq_en = 0;
  endtask

  task automatic t_baud();
    br = 6; baud_div = 12'd6; clocks(50);
    send_frame(8'h3C, 1, -1);
    settle();
    chk("R4 data at div 6", rx_data, 8'h3C);
    chk("R4 full at div 6", st_full, 1);
    clocks(1);
    rd_status(); rd_data();
    br = 4; baud_div = 12'd4; clocks(50);
  endtask

  task automatic t_false_start();
    rxd = 0; clocks(3 * br); rxd = 1; clocks(40 * br);
    settle();
    chk("R3 short low ignored", st_full, 0);
    clocks(1);
    send_frame(8'h01, 1, -1);
    settle();
    chk("R3 next frame ok", rx_data, 8'h01);
    clocks(1);
    rd_status(); rd_data();
  endtask

  task automatic t_noise();
    send_frame(8'h5A, 1, 4);
    settle();
    chk("R8 data majority", rx_data, 8'h5A);
    chk("R8 noise set", st_noise, 1);
    chk("R9 no framing", st_frame, 0);
    clocks(1);
    rd_status(); rd_data(); settle();
    chk("R5 noise cleared", st_noise, 0);
    clocks(1);
  endtask

  task automatic t_framing();
    send_frame(8'hC3, 0, -1);
    settle();
    chk("R9 framing set", st_frame, 1);
    chk("R9 data loaded", rx_data, 8'hC3);
    clocks(1);
    rd_status(); rd_data(); settle();
    chk("R5 framing cleared", st_frame, 0);
    clocks(1);
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 1, -1);
    send_frame(8'h22, 1, -1);
    settle();
    chk("R6 first kept", rx_data, 8'h11);
    chk("R7 no overrun yet", st_overrun, 0);
    clocks(1);
    send_frame(8'h33, 1, -1);
    settle();
    chk("R7 overrun set", st_overrun, 1);
    chk("R7 data unchanged", rx_data, 8'h11);
    clocks(1);
    rd_status(); rd_data(); settle();
    chk("R6 parked moved", rx_data, 8'h22);
    chk("R6 full again", st_full, 1);
    chk("R7 overrun cleared", st_overrun, 0);
    clocks(1);
    rd_status(); rd_data(); settle();
    chk("R7 third discarded", st_full, 0);
    clocks(1);
  endtask

  task automatic t_disabled();
    rx_en = 0;
    send_frame(8'h77, 1, -1);
    settle();
    chk("R11 nothing received", st_full, 0);
    clocks(1);
    rx_en = 1; clocks(40);
  endtask

  initial begin
    fork
      begin
        clocks(5);
        rst_n = 1; clocks(2);
        t_reset();
        clocks(1);
        rx_en = 1; clocks(40);
        t_basic();
        t_baud();
        t_false_start();
        t_noise();
        t_framing();
        t_overrun();
        t_disabled();
      end
      begin
        repeat (190000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule